// File: doc/BRIEF.md
# Asynchronous SRAM interface controller

This block lets a clocked host read and write an external asynchronous static RAM of 128K bytes. The host offers one request at a time over a valid/ready handshake carrying a write flag, a 17-bit address and a byte of write data. Read results come back on a byte-wide bus with a single-cycle valid strobe. On the memory side the controller drives two chip selects of opposite polarity, an active-low write strobe, an active-low output enable and the address bus. The data bus is split into an outgoing byte, an incoming byte and a drive enable, so that the pad ring can build the bidirectional pins.

Every strobe phase lasts a whole number of clock cycles. Each count is derived at elaboration from the clock period and the nanosecond minimums of the selected speed grade, rounded up and never below one cycle. The controller is a six-state machine:
- IDLE: deselected, ready for a request.
- WR_SETUP: one cycle, selected, write data driven, write strobe high.
- WR_PULSE: write strobe low.
- WR_RECOVER: one cycle, strobe high, address and data held.
- RD_ACCESS: selected, output enable low.
- RD_RELEASE: deselected, bus undriven, while the memory's drivers let go.

The transitions are:
- IDLE goes to WR_SETUP on an accepted write, and to RD_ACCESS on an accepted read.
- WR_SETUP goes to WR_PULSE, WR_PULSE to WR_RECOVER, and WR_RECOVER to IDLE.
- RD_ACCESS goes to RD_RELEASE, and RD_RELEASE to IDLE.

Each timed state leaves when its phase count expires.

Top module: `sram_ctrl`

## Requirements
- R1: After reset and whenever idle, both selects are inactive (`mem_en_n`=1, `mem_en`=0), `mem_wr_n`=1, `mem_out_en_n`=1, `mem_dq_oe`=0, `req_ready`=1 and `rsp_valid`=0.
- R2: A request is taken only on a cycle with `req_valid` and `req_ready` both high. `req_ready` is low from the next cycle until the transaction ends, and requests offered meanwhile have no effect.
- R3: A write holds `req_ready` low for 1 + N_WP + 1 cycles: a setup cycle with strobe high, N_WP cycles with `mem_wr_n` low, and a recovery cycle. Both selects are active whenever `mem_wr_n` is low. With a 10 ns clock and the fast grade, N_WP = 7.
- R4: During a write, `mem_out_en_n` stays high, `mem_dq_oe` is high and `mem_dq_out` carries the request's data, so that data is stored at the request's address.
- R5: `mem_addr` does not change in a cycle that follows a cycle with `mem_wr_n` low.
- R6: A read holds selects active and `mem_out_en_n` low for N_RD cycles (7 with a 10 ns clock and the fast grade). It samples `mem_dq_in` on the last of them and raises `rsp_valid` for exactly one cycle with that byte. A write produces no `rsp_valid`.
- R7: After a read, N_REL cycles (3 at 10 ns) follow with the memory deselected, `mem_out_en_n` high and `mem_dq_oe` low before `req_ready` returns. `mem_dq_oe` is never raised within N_REL cycles of `mem_out_en_n` being low.
- R8: `mem_dq_oe` and a low `mem_out_en_n` never occur in the same cycle.
- R9: `SPEED_GRADE`=1 selects the slow grade. At 10 ns this gives N_WP = 8 (write busy 10 cycles) and N_RD = 10 (read busy 13 cycles).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request offered |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle strobe for read data |
| rsp_rdata | output | 8 | Read data |
| mem_en_n | output | 1 | Active-low chip select |
| mem_en | output | 1 | Active-high chip select |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_out_en_n | output | 1 | Active-low memory output enable |
| mem_addr | output | 17 | Memory address |
| mem_dq_out | output | 8 | Data to memory |
| mem_dq_in | input | 8 | Data from memory |
| mem_dq_oe | output | 1 | Drive enable for the data pins |

## Verification
The hardest case to reach is a write that comes straight after a read. Only here does the release window stand between the memory still driving the bus and the controller starting to drive it. The random stream draws addresses from a small pool plus the two end addresses, and leaves gaps of zero to two idle cycles. Read-then-write pairs with no gap therefore occur often, as do rereads of freshly written bytes. A directed case offers a second write while the controller is busy and then reads that address back unchanged. A second instance built for the slow grade confirms the recomputed phase lengths.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_RECOVER,
        ST_RD_ACCESS,
        ST_RD_RELEASE
    } ctrl_state_e;

    // Nanosecond minimums of one speed grade
    typedef struct packed {
        logic [15:0] cyc_wr;
        logic [15:0] pulse;
        logic [15:0] addr_to_end;
        logic [15:0] sel_to_end;
        logic [15:0] data_setup;
        logic [15:0] cyc_rd;
        logic [15:0] addr_acc;
        logic [15:0] sel_acc;
        logic [15:0] oe_acc;
        logic [15:0] drv_off;
    } mem_timing_t;

    function automatic mem_timing_t grade_timing(input int grade);
        mem_timing_t t;
        if (grade == 0) begin
            t.cyc_wr = 16'd70;  t.pulse = 16'd55;  t.addr_to_end = 16'd65;
            t.sel_to_end = 16'd65; t.data_setup = 16'd30;
            t.cyc_rd = 16'd70;  t.addr_acc = 16'd70; t.sel_acc = 16'd70;
            t.oe_acc = 16'd35;  t.drv_off = 16'd25;
        end else begin
            t.cyc_wr = 16'd100; t.pulse = 16'd70;  t.addr_to_end = 16'd80;
            t.sel_to_end = 16'd80; t.data_setup = 16'd40;
            t.cyc_rd = 16'd100; t.addr_acc = 16'd100; t.sel_acc = 16'd100;
            t.oe_acc = 16'd50;  t.drv_off = 16'd30;
        end
        return t;
    endfunction

    function automatic int ns_to_cycles(input int ns, input int period);
        int c;
        c = (ns + period - 1) / period;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctrl_phase_timer.sv
module sram_ctrl_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n)       count <= '0;
        else if (restart) count <= '0;
        else              count <= count + CNT_W'(1);
    end
endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int N_WP  = 7,
    parameter int N_RD  = 7,
    parameter int N_REL = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [CNT_W-1:0] phase_cnt,
    output logic             req_ready,
    output logic             accept,
    output logic             restart,
    output logic             capture,
    output logic             mem_en_n,
    output logic             mem_en,
    output logic             mem_wr_n,
    output logic             mem_out_en_n,
    output logic             dq_drive
);
    ctrl_state_e state, state_n;
    logic        phase_last;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Phase expiry and next state
    always_comb begin
        phase_last = 1'b0;
        state_n    = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) state_n = req_write ? ST_WR_SETUP : ST_RD_ACCESS;
            end
            ST_WR_SETUP: begin
                phase_last = 1'b1;
                state_n    = ST_WR_PULSE;
            end
            ST_WR_PULSE: begin
                phase_last = (phase_cnt == CNT_W'(N_WP - 1));
                if (phase_last) state_n = ST_WR_RECOVER;
            end
            ST_WR_RECOVER: begin
                phase_last = 1'b1;
                state_n    = ST_IDLE;
            end
            ST_RD_ACCESS: begin
                phase_last = (phase_cnt == CNT_W'(N_RD - 1));
                if (phase_last) state_n = ST_RD_RELEASE;
            end
            ST_RD_RELEASE: begin
                phase_last = (phase_cnt == CNT_W'(N_REL - 1));
                if (phase_last) state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign restart   = phase_last || (state == ST_IDLE);
    assign capture   = (state == ST_RD_ACCESS) && phase_last;

    // Memory strobes decoded from the state
    always_comb begin
        mem_en_n     = 1'b1;
        mem_en       = 1'b0;
        mem_wr_n     = 1'b1;
        mem_out_en_n = 1'b1;
        dq_drive     = 1'b0;
        unique case (state)
            ST_IDLE, ST_RD_RELEASE: ;
            ST_WR_SETUP, ST_WR_RECOVER: begin
                mem_en_n = 1'b0; mem_en = 1'b1; dq_drive = 1'b1;
            end
            ST_WR_PULSE: begin
                mem_en_n = 1'b0; mem_en = 1'b1; dq_drive = 1'b1;
                mem_wr_n = 1'b0;
            end
            ST_RD_ACCESS: begin
                mem_en_n = 1'b0; mem_en = 1'b1; mem_out_en_n = 1'b0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              capture,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
        end else if (accept) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= capture;
            if (capture) rsp_rdata <= mem_dq_in;
        end
    end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 10,
    parameter int SPEED_GRADE   = 0,
    parameter int ADDR_W        = 17,
    parameter int DATA_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_en_n,
    output logic              mem_en,
    output logic              mem_wr_n,
    output logic              mem_out_en_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe
);
    localparam mem_timing_t TM = grade_timing(SPEED_GRADE);

    localparam int N_WP = max2(
        max2(ns_to_cycles(int'(TM.pulse), CLK_PERIOD_NS),
             ns_to_cycles(int'(TM.addr_to_end), CLK_PERIOD_NS)),
        max2(max2(ns_to_cycles(int'(TM.sel_to_end), CLK_PERIOD_NS),
                  ns_to_cycles(int'(TM.data_setup), CLK_PERIOD_NS)),
             max2(ns_to_cycles(int'(TM.cyc_wr), CLK_PERIOD_NS) - 2, 1)));
    localparam int N_RD = max2(
        max2(ns_to_cycles(int'(TM.cyc_rd), CLK_PERIOD_NS),
             ns_to_cycles(int'(TM.addr_acc), CLK_PERIOD_NS)),
        max2(ns_to_cycles(int'(TM.sel_acc), CLK_PERIOD_NS),
             ns_to_cycles(int'(TM.oe_acc), CLK_PERIOD_NS)));
    localparam int N_REL = ns_to_cycles(int'(TM.drv_off), CLK_PERIOD_NS);
    localparam int N_MAX = max2(max2(N_WP, N_RD), N_REL);
    localparam int CNT_W = $clog2(N_MAX + 1);

    logic             accept, restart, capture;
    logic [CNT_W-1:0] phase_cnt;

    sram_ctrl_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .count   (phase_cnt)
    );

    sram_ctrl_fsm #(
        .CNT_W (CNT_W),
        .N_WP  (N_WP),
        .N_RD  (N_RD),
        .N_REL (N_REL)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .phase_cnt    (phase_cnt),
        .req_ready    (req_ready),
        .accept       (accept),
        .restart      (restart),
        .capture      (capture),
        .mem_en_n     (mem_en_n),
        .mem_en       (mem_en),
        .mem_wr_n     (mem_wr_n),
        .mem_out_en_n (mem_out_en_n),
        .dq_drive     (mem_dq_oe)
    );

    sram_ctrl_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .capture    (capture),
        .mem_dq_in  (mem_dq_in),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata)
    );
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
    parameter int ADDR_W = 17,
    parameter int N_REL  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              mem_en_n,
    input logic              mem_en,
    input logic              mem_wr_n,
    input logic              mem_out_en_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_dq_oe
);
    localparam int RW = $clog2(N_REL + 1);

    // Cycles since the memory output enable was last low, saturating
    logic [RW-1:0] since_read;
    always_ff @(posedge clk) begin
        if (!rst_n)                     since_read <= RW'(N_REL);
        else if (!mem_out_en_n)         since_read <= '0;
        else if (since_read < RW'(N_REL)) since_read <= since_read + RW'(1);
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_wr_n && mem_out_en_n && !mem_dq_oe && mem_en_n && !mem_en));

    assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_write_selected_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr_n |-> (!mem_en_n && mem_en));

    assert_write_oe_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr_n |-> (mem_out_en_n && mem_dq_oe));

    assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr_n |=> $stable(mem_addr));

    assert_rsp_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_release_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_out_en_n) |-> (!req_ready && mem_en_n && !mem_en && !mem_dq_oe));

    assert_turnaround_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (since_read >= RW'(N_REL)));

    assert_no_contention_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_out_en_n);
endmodule

bind sram_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W), .N_REL(N_REL)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .rsp_valid    (rsp_valid),
    .mem_en_n     (mem_en_n),
    .mem_en       (mem_en),
    .mem_wr_n     (mem_wr_n),
    .mem_out_en_n (mem_out_en_n),
    .mem_addr     (mem_addr),
    .mem_dq_oe    (mem_dq_oe)
);

// File: tb/tb_sram_ctrl.sv
`timescale 1ns/1ps
module tb_sram_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    int n_checks = 0;
    int n_err    = 0;

    logic        req_valid = 1'b0, req_write = 1'b0, use_slow = 1'b0;
    logic [16:0] req_addr  = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  dq_in_r   = 8'hEE;

    logic        f_ready, f_rsp_valid, f_en_n, f_en, f_wr_n, f_oe_n, f_dq_oe;
    logic [7:0]  f_rdata, f_dq_out;
    logic [16:0] f_addr;
    logic        s_ready, s_rsp_valid, s_en_n, s_en, s_wr_n, s_oe_n, s_dq_oe;
    logic [7:0]  s_rdata, s_dq_out;
    logic [16:0] s_addr;

    sram_ctrl #(.CLK_PERIOD_NS(10), .SPEED_GRADE(0)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid && !use_slow), .req_ready(f_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(f_rsp_valid), .rsp_rdata(f_rdata),
        .mem_en_n(f_en_n), .mem_en(f_en), .mem_wr_n(f_wr_n), .mem_out_en_n(f_oe_n),
        .mem_addr(f_addr), .mem_dq_out(f_dq_out), .mem_dq_in(dq_in_r), .mem_dq_oe(f_dq_oe)
    );

    sram_ctrl #(.CLK_PERIOD_NS(10), .SPEED_GRADE(1)) dut_slow (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid && use_slow), .req_ready(s_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(s_rsp_valid), .rsp_rdata(s_rdata),
        .mem_en_n(s_en_n), .mem_en(s_en), .mem_wr_n(s_wr_n), .mem_out_en_n(s_oe_n),
        .mem_addr(s_addr), .mem_dq_out(s_dq_out), .mem_dq_in(dq_in_r), .mem_dq_oe(s_dq_oe)
    );

    // Muxed view of whichever controller is in use
    logic        m_ready, m_rsp_valid, m_en_n, m_en, m_wr_n, m_oe_n, m_dq_oe;
    logic [7:0]  m_rdata, m_dq_out;
    logic [16:0] m_addr;
    assign m_ready     = use_slow ? s_ready     : f_ready;
    assign m_rsp_valid = use_slow ? s_rsp_valid : f_rsp_valid;
    assign m_rdata     = use_slow ? s_rdata     : f_rdata;
    assign m_en_n      = use_slow ? s_en_n      : f_en_n;
    assign m_en        = use_slow ? s_en        : f_en;
    assign m_wr_n      = use_slow ? s_wr_n      : f_wr_n;
    assign m_oe_n      = use_slow ? s_oe_n      : f_oe_n;
    assign m_dq_oe     = use_slow ? s_dq_oe     : f_dq_oe;
    assign m_dq_out    = use_slow ? s_dq_out    : f_dq_out;
    assign m_addr      = use_slow ? s_addr      : f_addr;

    function automatic logic [7:0] fill_pat(input logic [16:0] a);
        return a[7:0] ^ a[15:8] ^ {7'h2D, a[16]};
    endfunction

    // Memory model and protocol monitor
    logic [7:0]  mem_model [int];
    logic [7:0]  exp_mem   [int];
    int          wr_run = 0, wr_last = 0, oe_run = 0, oe_last = 0;
    int          viol_r4 = 0, viol_r5 = 0, viol_r8 = 0;
    logic        prev_wr_low = 1'b0;
    logic [16:0] prev_addr = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!m_en_n && m_en && !m_wr_n) mem_model[int'(m_addr)] = m_dq_out;
            if (!m_en_n && m_en && m_wr_n && !m_oe_n)
                dq_in_r = mem_model.exists(int'(m_addr)) ? mem_model[int'(m_addr)] : fill_pat(m_addr);
            else
                dq_in_r = 8'hEE;
            if (!m_wr_n && (!m_oe_n || !m_dq_oe)) viol_r4++;
            if (prev_wr_low && m_addr != prev_addr) viol_r5++;
            if (m_dq_oe && !m_oe_n) viol_r8++;
            prev_wr_low = !m_wr_n;
            prev_addr   = m_addr;
            if (!m_wr_n) wr_run++;
            else if (wr_run != 0) begin wr_last = wr_run; wr_run = 0; end
            if (!m_oe_n) oe_run++;
            else if (oe_run != 0) begin oe_last = oe_run; oe_run = 0; end
        end
    end

    task automatic check(input string req, input int act, input int exp, input string what);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_op(input logic wr, input logic [16:0] a, input logic [7:0] d);
        int busy = 0, rel = 0, nrsp = 0;
        logic seen = 1'b0;
        logic [7:0] rd = '0;
        @(negedge clk);
        while (!m_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        while (!m_ready) begin
            if (m_rsp_valid) begin nrsp++; rd = m_rdata; seen = 1'b1; end
            if (seen) rel++;
            busy++;
            @(negedge clk);
        end
        if (wr) begin
            exp_mem[int'(a)] = d;
            check(use_slow ? "R9" : "R3", busy, use_slow ? 10 : 9, "write busy cycles");
            check(use_slow ? "R9" : "R3", wr_last, use_slow ? 8 : 7, "write pulse cycles");
            check("R6", nrsp, 0, "rsp count on write");
        end else begin
            check(use_slow ? "R9" : "R6", busy, use_slow ? 13 : 10, "read busy cycles");
            check(use_slow ? "R9" : "R6", oe_last, use_slow ? 10 : 7, "read access cycles");
            check("R6", nrsp, 1, "rsp count on read");
            check("R7", rel, 3, "release cycles after read");
            check("R4", int'(rd),
                  int'(exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : fill_pat(a)), "read data");
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_err++;
        $display("FAIL R2 watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", int'(f_en_n), 1, "en_n after reset");
        check("R1", int'(f_en), 0, "en after reset");
        check("R1", int'(f_wr_n), 1, "wr_n after reset");
        check("R1", int'(f_oe_n), 1, "out_en_n after reset");
        check("R1", int'(f_dq_oe), 0, "dq_oe after reset");
        check("R1", int'(f_ready), 1, "ready after reset");
        check("R1", int'(f_rsp_valid), 0, "rsp_valid after reset");

        // Directed corners: end addresses, read-then-write back to back
        do_op(1'b1, 17'h00000, 8'h3C);
        do_op(1'b1, 17'h1FFFF, 8'hC3);
        do_op(1'b0, 17'h00000, 8'h00);
        do_op(1'b1, 17'h00000, 8'h81);
        do_op(1'b0, 17'h1FFFF, 8'h00);
        do_op(1'b0, 17'h00000, 8'h00);
        do_op(1'b0, 17'h0ABCD, 8'h00);

        // R2: a request offered while busy has no effect
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00010; req_wdata = 8'h11;
        @(negedge clk);
        req_addr = 17'h00020; req_wdata = 8'h99;
        check("R2", int'(f_ready), 0, "ready low after accept");
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        while (!f_ready) @(negedge clk);
        exp_mem[32'h10] = 8'h11;
        do_op(1'b0, 17'h00020, 8'h00);
        do_op(1'b0, 17'h00010, 8'h00);

        // Constrained random traffic
        for (int i = 0; i < 150; i++) begin
            logic [16:0] a;
            int sel = $urandom_range(0, 9);
            if (sel == 0)      a = 17'h00000;
            else if (sel == 1) a = 17'h1FFFF;
            else               a = {13'h0A5A, 4'($urandom_range(0, 15))};
            repeat ($urandom_range(0, 2)) @(negedge clk);
            do_op(1'($urandom_range(0, 1)), a, 8'($urandom));
        end

        // R9: slow grade instance
        @(negedge clk);
        use_slow = 1'b1;
        do_op(1'b1, 17'h1FFFF, 8'hA5);
        do_op(1'b0, 17'h1FFFF, 8'h00);
        do_op(1'b1, 17'h00033, 8'h5E);
        do_op(1'b0, 17'h00033, 8'h00);

        check("R4", viol_r4, 0, "write cycles with out_en low or bus undriven");
        check("R5", viol_r5, 0, "address changes after low write strobe");
        check("R8", viol_r8, 0, "bus contention cycles");

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule